// File: doc/BRIEF.md
# Pin Interrupt Detection Unit

This unit watches eight general-purpose input pins and turns selected conditions on them into one interrupt line. Each pin has a 3-bit trigger code. The code selects one of four behaviours: no trigger, a level condition (pin high or pin low), a forced-pending condition, or an edge condition (rising, falling or either). The pins are asynchronous to the unit clock. Each pin passes through a two-stage synchroniser, and edges are found by comparing each synchronised sample with the one taken a clock earlier.

Software reaches the unit through a plain register port. The port has a write strobe, a read strobe, a byte offset and a 32-bit data word. Five registers are mapped:

- a packed trigger-code register
- a per-pin enable mask
- a write-only clear register
- a raw pending view
- a masked pending view

Edge conditions are held pending until software clears them. Level and forced conditions always show the live state. The interrupt output is the registered OR of the masked pending bits.

Top module: `pin_irq_unit`

## Requirements
- R1: After synchronous reset all trigger codes and mask bits are zero, the pending views read zero and `irq_o` is low.
- R2: The trigger code for pin i lives in bits [3i+2:3i] of the word at byte offset 12; bits 31:24 of that word read back as zero whatever was written.
- R3: Code 1 makes a pin pending while its synchronised level is high, code 2 while it is low; writing a clear bit for such a pin has no lasting effect.
- R4: Code 3 keeps a pin pending at all times; codes 0 and 4 never make a pin pending.
- R5: Codes 5 (rising), 6 (falling) and 7 (either edge) latch a pending bit on the matching edge; the bit stays set after the pin returns.
- R6: Writing a word to byte offset 20 clears the latched pending bit of every pin whose bit is 1; pins whose bit is 0 keep their state.
- R7: When a qualifying edge and a clear for the same pin land on the same clock, the pin stays pending.
- R8: Byte offset 24 reads the raw pending bits of all pins regardless of mask; byte offset 28 reads raw pending ANDed with the mask written at byte offset 16 (bit i = pin i).
- R9: `irq_o` is the OR of the masked pending bits, delayed by one register stage.
- R10: A read returns its data on `rd_data` one clock after the cycle in which `rd_en` was sampled; unmapped offsets and the clear register read as zero.
- R11: A pin change reaches the pending logic only after two synchronising flops, so with code 1 and the pin masked in, `irq_o` rises on the third clock edge after the pin goes high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Unit clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | 8 | Asynchronous general-purpose input pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The risky coincidence is a clear write and a fresh edge reaching the same pending bit on the same clock. The bench first arranges for a falling-edge pin to be latched and then cleared. It then lowers the pin and times the clear write so that it is sampled exactly on the edge where the synchronised and delayed samples differ. A read of the raw view must then still show the pin pending. A clear alone on the next attempt must drop it, which shows that the collision case was really reached.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;

    typedef enum logic [2:0] {
        TRIG_NONE = 3'd0,
        TRIG_HIGH = 3'd1,
        TRIG_LOW  = 3'd2,
        TRIG_SET  = 3'd3,
        TRIG_RSVD = 3'd4,
        TRIG_RISE = 3'd5,
        TRIG_FALL = 3'd6,
        TRIG_BOTH = 3'd7
    } trig_e;

    localparam int unsigned OFS_TRIG   = 12;
    localparam int unsigned OFS_MASK   = 16;
    localparam int unsigned OFS_CLEAR  = 20;
    localparam int unsigned OFS_RAW    = 24;
    localparam int unsigned OFS_MASKED = 28;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic edge_mode(trig_e m);
        return (m == TRIG_RISE) || (m == TRIG_FALL) || (m == TRIG_BOTH);
    endfunction

    function automatic logic edge_fires(trig_e m, edge_t e);
        case (m)
            TRIG_RISE: return e.rise;
            TRIG_FALL: return e.fall;
            TRIG_BOTH: return e.rise | e.fall;
            default:   return 1'b0;
        endcase
    endfunction

    function automatic logic live_status(trig_e m, logic lvl);
        case (m)
            TRIG_HIGH: return lvl;
            TRIG_LOW:  return ~lvl;
            TRIG_SET:  return 1'b1;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
    parameter int unsigned N      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stage_q[k] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pin_irq_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 3
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   lvl_i,
    input  logic [N*CW-1:0] trig_i,
    input  logic [N-1:0]   clear_i,
    output logic [N-1:0]   raw_o,
    output logic [N-1:0]   hit_o,
    output logic [N-1:0]   pend_o
);
    logic [N-1:0] prev_q;
    logic [N-1:0] pend_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl_i;
    end

    for (genvar i = 0; i < N; i++) begin : g_pin
        trig_e mode;
        edge_t ev;
        logic  is_edge;

        assign mode    = trig_e'(trig_i[i*CW +: CW]);
        assign ev.rise = lvl_i[i] & ~prev_q[i];
        assign ev.fall = ~lvl_i[i] & prev_q[i];
        assign is_edge = edge_mode(mode);
        assign hit_o[i] = edge_fires(mode, ev);

        always_ff @(posedge clk) begin
            if (rst || !is_edge) pend_q[i] <= 1'b0;
            else                 pend_q[i] <= (pend_q[i] & ~clear_i[i]) | hit_o[i];
        end

        assign raw_o[i] = is_edge ? pend_q[i] : live_status(mode, lvl_i[i]);
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
    import pin_irq_pkg::*;
#(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 3,
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wr_data,
    input  logic [N-1:0]    raw_i,
    input  logic [N-1:0]    masked_i,
    output logic [N*CW-1:0] trig_o,
    output logic [N-1:0]    mask_o,
    output logic [N-1:0]    clear_o,
    output logic [DW-1:0]   rd_data
);
    localparam int unsigned TW = N * CW;

    logic [TW-1:0] trig_q;
    logic [N-1:0]  mask_q;
    logic [DW-1:0] rd_next;
    logic          unused_hi;

    assign unused_hi = ^wr_data[DW-1:TW];

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_q <= '0;
            mask_q <= '0;
        end else if (wr_en) begin
            if (addr == AW'(OFS_TRIG)) trig_q <= wr_data[TW-1:0];
            if (addr == AW'(OFS_MASK)) mask_q <= wr_data[N-1:0];
        end
    end

    assign clear_o = (wr_en && addr == AW'(OFS_CLEAR)) ? wr_data[N-1:0] : '0;

    always_comb begin
        rd_next = '0;
        if      (addr == AW'(OFS_TRIG))   rd_next = DW'(trig_q);
        else if (addr == AW'(OFS_MASK))   rd_next = DW'(mask_q);
        else if (addr == AW'(OFS_RAW))    rd_next = DW'(raw_i);
        else if (addr == AW'(OFS_MASKED)) rd_next = DW'(masked_i);
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    assign trig_o = trig_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/pin_irq_unit.sv
module pin_irq_unit
    import pin_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS    = 8,
    parameter int unsigned TRIG_W      = 3,
    parameter int unsigned ADDR_W      = 8,
    parameter int unsigned DATA_W      = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);
    localparam int unsigned TW = NUM_PINS * TRIG_W;

    logic [NUM_PINS-1:0] lvl_sync;
    logic [TW-1:0]       cfg_q;
    logic [NUM_PINS-1:0] mask_q;
    logic [NUM_PINS-1:0] ack_pulse;
    logic [NUM_PINS-1:0] raw_stat;
    logic [NUM_PINS-1:0] masked_stat;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] pend_q;
    logic                irq_q;

    pin_irq_sync #(.N(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .async_i(pins_i),
        .sync_o (lvl_sync)
    );

    pin_irq_detect #(.N(NUM_PINS), .CW(TRIG_W)) u_detect (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (lvl_sync),
        .trig_i (cfg_q),
        .clear_i(ack_pulse),
        .raw_o  (raw_stat),
        .hit_o  (edge_hit),
        .pend_o (pend_q)
    );

    pin_irq_regs #(.N(NUM_PINS), .CW(TRIG_W), .AW(ADDR_W), .DW(DATA_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .raw_i   (raw_stat),
        .masked_i(masked_stat),
        .trig_o  (cfg_q),
        .mask_o  (mask_q),
        .clear_o (ack_pulse),
        .rd_data (rd_data)
    );

    assign masked_stat = raw_stat & mask_q;

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |masked_stat;
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
    parameter int unsigned N  = 8,
    parameter int unsigned CW = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            irq_o,
    input logic [N*CW-1:0] cfg,
    input logic [N-1:0]    raw,
    input logic [N-1:0]    masked,
    input logic [N-1:0]    pend,
    input logic [N-1:0]    edge_hit,
    input logic [N-1:0]    ack
);
    logic [N-1:0] forced;

    always_comb begin
        for (int i = 0; i < N; i++) forced[i] = (cfg[i*CW +: CW] == CW'(3));
    end

    // R1
    a_r1_irq_low_after_reset: assert property (@(posedge clk)
        rst |=> !irq_o);

    // R9
    a_r9_irq_registered_or: assert property (@(posedge clk) disable iff (rst)
        irq_o == $past(|masked));

    // R4
    a_r4_forced_pending: assert property (@(posedge clk) disable iff (rst)
        (raw & forced) == forced);

    // R5
    a_r5_latch_needs_edge: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(edge_hit)) == '0));

    // R6
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        ((ack & ~edge_hit) != '0) |=> ((pend & $past(ack & ~edge_hit)) == '0));

    // R7
    a_r7_edge_beats_clear: assert property (@(posedge clk) disable iff (rst)
        ((ack & edge_hit) != '0) |=> ((pend & $past(ack & edge_hit)) == $past(ack & edge_hit)));
endmodule

bind pin_irq_unit pin_irq_chk #(.N(NUM_PINS), .CW(TRIG_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_o   (irq_o),
    .cfg     (cfg_q),
    .raw     (raw_stat),
    .masked  (masked_stat),
    .pend    (pend_q),
    .edge_hit(edge_hit),
    .ack     (ack_pulse)
);

// File: tb/pin_irq_unit_tb.sv
module pin_irq_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pins = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    pin_irq_unit u_dut (
        .clk(clk), .rst(rst), .pins_i(pins), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic judge(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // monitor: compare registered read data the half cycle after capture
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            judge(rd_data, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        judge({31'd0, irq_o}, 32'd0, "R1 irq after reset");
        reg_rd(8'd12, 32'd0, "R1 trig reset");
        reg_rd(8'd16, 32'd0, "R1 mask reset");
        reg_rd(8'd24, 32'd0, "R1 raw reset");
        reg_rd(8'd28, 32'd0, "R1 masked reset");

        reg_wr(8'd12, 32'hFFFF_FFFF);
        reg_rd(8'd12, 32'h00FF_FFFF, "R2 top bits zero");
        // pin0=1 pin1=2 pin2=3 pin3=4 pin4=5 pin5=6 pin6=7 pin7=0
        reg_wr(8'd12, 32'h001F_58D1);
        reg_rd(8'd12, 32'h001F_58D1, "R2 field packing");
        settle();
        reg_rd(8'd24, 32'h06, "R3 R4 pins low");
        reg_rd(8'd28, 32'h00, "R8 masked all off");
        judge({31'd0, irq_o}, 32'd0, "R9 irq masked off");

        @(negedge clk); pins = 8'hFF;
        settle();
        reg_rd(8'd24, 32'h55, "R3 R5 pins high");

        @(negedge clk); pins = 8'h00;
        settle();
        reg_rd(8'd24, 32'h76, "R5 sticky edges");

        reg_wr(8'd16, 32'h30);
        reg_rd(8'd28, 32'h30, "R8 masked view");
        reg_rd(8'd24, 32'h76, "R8 raw ignores mask");
        settle();
        judge({31'd0, irq_o}, 32'd1, "R9 irq high");

        reg_wr(8'd20, 32'h10);
        reg_rd(8'd24, 32'h66, "R6 selective clear");
        reg_wr(8'd20, 32'h06);
        reg_rd(8'd24, 32'h66, "R3 clear on live pins");
        reg_rd(8'd20, 32'h00, "R10 clear reg reads zero");
        reg_rd(8'h40, 32'h00, "R10 unmapped zero");

        reg_wr(8'd20, 32'h60);
        reg_rd(8'd24, 32'h06, "R6 clear rest");
        settle();
        judge({31'd0, irq_o}, 32'd0, "R9 irq drops");

        // R7 collision on pin5 (falling edge)
        @(negedge clk); pins = 8'h20;
        settle();
        reg_wr(8'd20, 32'hFF);
        reg_rd(8'd24, 32'h06, "R6 clear before collision");
        @(negedge clk); pins = 8'h00;
        @(posedge clk);
        @(posedge clk);
        reg_wr(8'd20, 32'h20);
        reg_rd(8'd24, 32'h26, "R7 edge wins over clear");
        reg_wr(8'd20, 32'h20);
        reg_rd(8'd24, 32'h06, "R6 clear alone");

        // R11 synchroniser latency via irq
        reg_wr(8'd16, 32'h01);
        settle();
        judge({31'd0, irq_o}, 32'd0, "R11 irq idle");
        @(negedge clk); pins = 8'h01;
        @(negedge clk);
        judge({31'd0, irq_o}, 32'd0, "R11 after edge 1");
        @(negedge clk);
        judge({31'd0, irq_o}, 32'd0, "R11 after edge 2");
        @(negedge clk);
        judge({31'd0, irq_o}, 32'd1, "R11 R9 after edge 3");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: actual %0d reads outstanding expected 0", exp_q.size());
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule